// File: doc/BRIEF.md
# Parallel EPROM Read Access Controller

This block sits on the host side of a bank of byte-wide UV-erasable PROMs that share one address bus and one data bus. A host hands it a read request carrying a flat byte address. The upper address bits pick one device. The block lowers that device's chip-enable line alone, and every other device stays in low-power standby with its outputs floating. The block also lowers a single output-enable line that is common to the whole bank and serves as the read strobe. It counts clock cycles until the part's access time has passed, captures the byte, and returns it with a one-cycle valid pulse.

The part's timing comes from two parameters, the clock period and a speed grade from 0 to 3, and each delay is rounded up to whole cycles. The grades have these delays:

- Access time: 200, 250, 300 and 450 ns.
- Output-enable-to-data delay: 100 ns for grades 0 and 1, and 150 ns for grades 2 and 3.
- Bus-float time: 60 ns for grades 0 and 1, and 130 ns for grades 2 and 3.

The output enable is held back from the chip enable by the difference between the access delay and the output-enable delay. This shortens the time the bus is driven without lengthening the access. After release, the block refuses new requests until the bus-float time has passed, so two devices can never fight over the data lines.

Top module: `eprom_read_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, req_ready is 1, every mem_ce_n bit is 1, mem_oe_n is 1 and rd_valid is 0.
- R2: A request is taken on a clock edge with req_valid and req_ready both high. From the next cycle, mem_ce_n bit i is low only for i equal to req_addr[ADDR_W-1:12], and mem_addr carries req_addr[11:0].
- R3: At no time is more than one mem_ce_n bit low.
- R4: With ACC = ceil(tACC/period) and OEC = ceil(tOE/period), mem_oe_n goes low max(ACC-OEC,0) cycles after the chip enable falls. It stays low up to and including the ACC-th cycle after acceptance, and it is low only while a request is in progress.
- R5: rd_valid is high for exactly one cycle and carries the value of mem_dq sampled at the edge that ends that access.
- R6: In the cycle rd_valid is high, mem_oe_n and all mem_ce_n bits are already high.
- R7: With DF = ceil(tDF/period), req_ready stays low until DF cycles after the rd_valid cycle. No chip enable falls earlier than DF cycles after the previous one rose.
- R8: Requests presented while req_ready is low are ignored: mem_addr, mem_ce_n and the returned data of the running access are unchanged, and no extra rd_valid appears.
- R9: If the device index is NUM_DEV or greater, no chip enable falls, the output enable and the timing run as usual, and rd_data returns 8'hFF.
- R10: rd_valid rises ACC+1 cycles after the accepting edge. For speed grade 0 to 3, tACC is 200/250/300/450 ns, tOE is 100/100/150/150 ns and tDF is 60/60/130/130 ns.
- R11: mem_addr holds steady for as long as any chip enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request |
| req_addr | input | ADDR_W | Flat byte address: device index above bit 11, byte offset below |
| req_ready | output | 1 | Request can be taken this cycle |
| rd_valid | output | 1 | One-cycle pulse marking returned data |
| rd_data | output | DATA_W | Returned byte |
| mem_addr | output | DEV_AW | Address bus to all devices |
| mem_ce_n | output | NUM_DEV | Active-low chip enable, one per device |
| mem_oe_n | output | 1 | Shared active-low output enable (read strobe) |
| mem_dq | input | DATA_W | Data bus from the devices |

## Verification
Two events can fall in the same cycle. The first is the end of the bus-float wait, which raises req_ready. The second is a waiting request being taken on that same edge. The bench provokes this by raising req_valid with a second address while the first access is still running, and holding it high without a break. The second request must then be refused through the whole access and float interval, and taken on the first edge where req_ready is high. The bench judges this by checking every cycle that mem_addr and the chip enable keep the first access's values, that only one rd_valid appears, and that the new chip enable falls only after the full float count. A bus model that returns inverted data until both the chip-enable and output-enable delays have passed exposes a capture that comes a cycle too early.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_FLOAT  = 2'd2
    } seq_state_e;

    // access time of the selected grade, in ns
    function automatic int grade_acc_ns(input int grade);
        case (grade)
            0:       return 200;
            1:       return 250;
            2:       return 300;
            default: return 450;
        endcase
    endfunction

    // output-enable to data delay, in ns
    function automatic int grade_oe_ns(input int grade);
        return (grade <= 1) ? 100 : 150;
    endfunction

    // time for the outputs to float after release, in ns
    function automatic int grade_df_ns(input int grade);
        return (grade <= 1) ? 60 : 130;
    endfunction

    // round a delay up to whole clock cycles
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

endpackage

// File: rtl/eprom_ce_decode.sv
module eprom_ce_decode #(
    parameter int NUM_DEV = 3,
    parameter int IDX_W   = 2
) (
    input  logic             sel_en,
    input  logic [IDX_W-1:0] sel_idx,
    output logic [NUM_DEV-1:0] ce_n,
    output logic             hit
);

    logic [NUM_DEV-1:0] match;

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
        assign match[i] = (sel_idx == IDX_W'(i));
        assign ce_n[i]  = ~(sel_en & match[i]);
    end

    assign hit = |match;

endmodule

// File: rtl/eprom_rd_seq.sv
module eprom_rd_seq
    import eprom_rd_pkg::*;
#(
    parameter int ACC_CYC  = 13,
    parameter int LEAD_CYC = 8,
    parameter int DF_CYC   = 3,
    parameter int DEV_AW   = 12,
    parameter int IDX_W    = 2,
    parameter int DATA_W   = 8,
    localparam int ADDR_W  = DEV_AW + IDX_W,
    localparam int CNT_MAX = (ACC_CYC > DF_CYC) ? ACC_CYC : DF_CYC,
    localparam int CNT_W   = $clog2(CNT_MAX + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              hit,
    input  logic [DATA_W-1:0] mem_dq,
    output logic              req_ready,
    output logic              sel_en,
    output logic [IDX_W-1:0]  sel_idx,
    output logic [DEV_AW-1:0] mem_addr,
    output logic              mem_oe_n,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DEV_AW-1:0] addr;
        logic              sel;
        logic              oe_n;
        logic              vld;
        logic [DATA_W-1:0] data;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st   = ST_ACCESS;
                    r_d.cnt  = '0;
                    r_d.idx  = req_addr[ADDR_W-1:DEV_AW];
                    r_d.addr = req_addr[DEV_AW-1:0];
                    r_d.sel  = 1'b1;
                    r_d.oe_n = (LEAD_CYC != 0);
                end
            end
            ST_ACCESS: begin
                if (r_q.cnt == CNT_W'(ACC_CYC)) begin
                    // access time has fully elapsed: take the byte, release bus
                    r_d.data = hit ? mem_dq : '1;
                    r_d.vld  = 1'b1;
                    r_d.sel  = 1'b0;
                    r_d.oe_n = 1'b1;
                    r_d.st   = ST_FLOAT;
                    r_d.cnt  = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                    if ((r_q.cnt + 1'b1) >= CNT_W'(LEAD_CYC)) begin
                        r_d.oe_n = 1'b0;
                    end
                end
            end
            ST_FLOAT: begin
                if (r_q.cnt == CNT_W'(DF_CYC - 1)) begin
                    r_d.st  = ST_IDLE;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: begin
                r_d.st   = ST_IDLE;
                r_d.cnt  = '0;
                r_d.sel  = 1'b0;
                r_d.oe_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, idx: '0, addr: '0,
                     sel: 1'b0, oe_n: 1'b1, vld: 1'b0, data: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign sel_en    = r_q.sel;
    assign sel_idx   = r_q.idx;
    assign mem_addr  = r_q.addr;
    assign mem_oe_n  = r_q.oe_n;
    assign rd_valid  = r_q.vld;
    assign rd_data   = r_q.data;

endmodule

// File: rtl/eprom_read_ctrl.sv
module eprom_read_ctrl
    import eprom_rd_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 20,
    parameter int SPEED_GRADE   = 1,
    parameter int NUM_DEV       = 3,
    parameter int DEV_AW        = 12,
    parameter int DATA_W        = 8,
    localparam int IDX_W        = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
    localparam int ADDR_W       = DEV_AW + IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               req_ready,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data,
    output logic [DEV_AW-1:0]  mem_addr,
    output logic [NUM_DEV-1:0] mem_ce_n,
    output logic               mem_oe_n,
    input  logic [DATA_W-1:0]  mem_dq
);

    localparam int ACC_CYC  = ns_to_cyc(grade_acc_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int OE_CYC   = ns_to_cyc(grade_oe_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int LEAD_CYC = (ACC_CYC > OE_CYC) ? (ACC_CYC - OE_CYC) : 0;
    localparam int DF_RAW   = ns_to_cyc(grade_df_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int DF_CYC   = (DF_RAW < 1) ? 1 : DF_RAW;

    logic             sel_en;
    logic [IDX_W-1:0] sel_idx;
    logic             hit;

    eprom_rd_seq #(
        .ACC_CYC  (ACC_CYC),
        .LEAD_CYC (LEAD_CYC),
        .DF_CYC   (DF_CYC),
        .DEV_AW   (DEV_AW),
        .IDX_W    (IDX_W),
        .DATA_W   (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .hit       (hit),
        .mem_dq    (mem_dq),
        .req_ready (req_ready),
        .sel_en    (sel_en),
        .sel_idx   (sel_idx),
        .mem_addr  (mem_addr),
        .mem_oe_n  (mem_oe_n),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    eprom_ce_decode #(
        .NUM_DEV (NUM_DEV),
        .IDX_W   (IDX_W)
    ) u_dec (
        .sel_en  (sel_en),
        .sel_idx (sel_idx),
        .ce_n    (mem_ce_n),
        .hit     (hit)
    );

endmodule

// File: rtl/eprom_read_ctrl_chk.sv
module eprom_read_ctrl_chk
    import eprom_rd_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 20,
    parameter int SPEED_GRADE   = 1,
    parameter int NUM_DEV       = 3,
    parameter int DEV_AW        = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               rd_valid,
    input logic [DEV_AW-1:0]  mem_addr,
    input logic [NUM_DEV-1:0] mem_ce_n,
    input logic               mem_oe_n
);

    localparam int DF_RAW = ns_to_cyc(grade_df_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int DF_CYC = (DF_RAW < 1) ? 1 : DF_RAW;

    logic       act;
    logic [7:0] gap_q;

    assign act = (mem_ce_n != '1);

    // cycles with every chip enable high, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= 8'hFF;
        end else if (act) begin
            gap_q <= 8'h00;
        end else if (gap_q != 8'hFF) begin
            gap_q <= gap_q + 8'h01;
        end
    end

    // R3
    one_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_ce_n));

    // R7
    float_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !$past(act)) |-> (gap_q >= 8'(DF_CYC)));

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R6
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (mem_oe_n && (&mem_ce_n)));

    // R8
    busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R4
    oe_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !req_ready);

    // R11
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && $past(act)) |-> $stable(mem_addr));

endmodule

bind eprom_read_ctrl eprom_read_ctrl_chk #(
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .SPEED_GRADE   (SPEED_GRADE),
    .NUM_DEV       (NUM_DEV),
    .DEV_AW        (DEV_AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n)
);

// File: tb/test_eprom_read_ctrl.sv
module test_eprom_read_ctrl;

    localparam int CLK_NS = 20;
    localparam int NDEV   = 3;
    localparam int ACC_B  = (250 + CLK_NS - 1) / CLK_NS;  // grade 1 -> 13
    localparam int OE_B   = (100 + CLK_NS - 1) / CLK_NS;  // 5
    localparam int LEAD_B = ACC_B - OE_B;                 // 8
    localparam int DF_B   = (60 + CLK_NS - 1) / CLK_NS;   // 3

    localparam logic [13:0] VEC [0:5] = '{
        14'h0000, 14'h1123, 14'h2FFF, 14'h0ABC, 14'h3055, 14'h2800
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [13:0] req_addr = '0;
    logic        req_ready;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [11:0] mem_addr;
    logic [2:0]  mem_ce_n;
    logic        mem_oe_n;
    logic [7:0]  mem_dq;

    int checks = 0;
    int failures = 0;
    int ce_cnt = 0;
    int oe_cnt = 0;

    always #(CLK_NS/2) clk = ~clk;

    eprom_read_ctrl #(
        .CLK_PERIOD_NS (CLK_NS),
        .SPEED_GRADE   (1),
        .NUM_DEV       (NDEV),
        .DEV_AW        (12),
        .DATA_W        (8)
    ) i_eprom_read_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .mem_addr  (mem_addr),
        .mem_ce_n  (mem_ce_n),
        .mem_oe_n  (mem_oe_n),
        .mem_dq    (mem_dq)
    );

    function automatic logic [7:0] pat(input int dev, input logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'(8'h5C + dev * 41);
    endfunction

    // bank model: wrong (inverted) data until both delays have elapsed
    always @(posedge clk) begin
        ce_cnt <= (mem_ce_n != 3'b111) ? ce_cnt + 1 : 0;
        oe_cnt <= (!mem_oe_n) ? oe_cnt + 1 : 0;
    end

    always_comb begin
        mem_dq = 8'hFF;
        for (int i = 0; i < NDEV; i++) begin
            if (!mem_ce_n[i] && !mem_oe_n) begin
                mem_dq = (ce_cnt >= ACC_B && oe_cnt >= OE_B) ?
                         pat(i, mem_addr) : ~pat(i, mem_addr);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic start(input logic [13:0] a);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
    endtask

    // follows one access cycle by cycle; k counts negedges after the accepting edge
    task automatic watch(input logic [13:0] a, input bit poke, input logic [13:0] pa);
        int         dev = int'(a[13:12]);
        bit         inr = (dev < NDEV);
        logic [2:0] exp_ce;
        logic [7:0] exp_d = inr ? pat(dev, a[11:0]) : 8'hFF;
        @(posedge clk);
        for (int k = 0; k <= ACC_B + DF_B + 1; k++) begin
            @(negedge clk);
            if (k == 0) req_valid = 1'b0;
            if (poke && k == 2) begin
                req_valid = 1'b1;
                req_addr  = pa;
            end
            exp_ce = (inr && k <= ACC_B) ? ~(3'b001 << dev) : 3'b111;
            chk(mem_ce_n == exp_ce, inr ? "R2" : "R9", "chip enable",
                int'(mem_ce_n), int'(exp_ce));
            chk($countones(~mem_ce_n) <= 1, "R3", "enables low", int'(mem_ce_n), 0);
            chk(mem_oe_n == !(k >= LEAD_B && k <= ACC_B), "R4", "output enable",
                int'(mem_oe_n), int'(!(k >= LEAD_B && k <= ACC_B)));
            chk(rd_valid == (k == ACC_B + 1), poke ? "R8" : "R10", "rd_valid timing",
                int'(rd_valid), int'(k == ACC_B + 1));
            chk(req_ready == (k >= ACC_B + 1 + DF_B), "R7", "ready after float",
                int'(req_ready), int'(k >= ACC_B + 1 + DF_B));
            if (k <= ACC_B) begin
                chk(mem_addr == a[11:0], poke ? "R8" : "R11", "address held",
                    int'(mem_addr), int'(a[11:0]));
            end
            if (k == ACC_B + 1) begin
                chk(rd_data == exp_d, inr ? "R5" : "R9", "read data",
                    int'(rd_data), int'(exp_d));
                chk(mem_oe_n && (mem_ce_n == 3'b111), "R6", "released at valid",
                    int'({mem_oe_n, mem_ce_n}), 4'hF);
            end
        end
    endtask

    task automatic chk_reset_state(input string what);
        chk(req_ready == 1'b1, "R1", what, int'(req_ready), 1);
        chk(mem_ce_n == 3'b111, "R1", what, int'(mem_ce_n), 7);
        chk(mem_oe_n == 1'b1, "R1", what, int'(mem_oe_n), 1);
        chk(rd_valid == 1'b0, "R1", what, int'(rd_valid), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run hung actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk_reset_state("during reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_reset_state("after reset");

        // table of addresses, each one a full access (index 3 is out of range, R9)
        for (int v = 0; v < 6; v++) begin
            start(VEC[v]);
            watch(VEC[v], 1'b0, '0);
        end

        // R8 and R7: a request held high during a busy access is taken only after float
        start(14'h1400);
        watch(14'h1400, 1'b1, 14'h2456);
        watch(14'h2456, 1'b0, '0);

        // R1: reset in the middle of an access
        start(14'h0010);
        repeat (4) @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk_reset_state("mid-access reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_reset_state("after mid-access reset");

        // access after the aborted one still completes normally (R2)
        start(14'h2A5A);
        watch(14'h2A5A, 1'b0, '0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule